// File: doc/BRIEF.md
# Temperature-Driven Fan PWM Duty Sequencer

This block drives a fan's PWM pin. The waveform has a fixed period of `PERIOD` clock cycles, and that period is reported read-only on a port. The high time per period is a programmable width, so the duty cycle is width divided by period. A new width can come from two places. Software can write one directly. The block can also pick one itself when a temperature sample crosses into a higher band of a threshold table.

The two kinds of change are announced differently.

- **Software change:** the "PWM changed" event is raised at once, and the tach-parameter flag is cleared. This tells the tach monitor to use the expected-period values that software loaded.
- **Hardware change:** the block first pulses a "temperature increase" event and applies the new width. It then waits a settling window of `SETTLE_CYCLES` cycles. Only after that does it pulse "PWM changed" and set the flag. This tells the tach monitor to use its built-in expected-period values.

Software writes that arrive during the settling window are held, and the newest one is applied when the window ends. Temperature conversion and register decoding are handled outside this block.

Top module: `fan_duty_sequencer`

## Requirements
- R1: `period_o` always equals `PERIOD`. An internal phase counter starts at 0 on the first cycle after reset and wraps after `PERIOD` cycles. `pwm_out` is high exactly in the cycles whose phase is below the active width.
- R2: A new target width becomes the active width only at a phase-0 cycle. A rising edge of `pwm_out` therefore happens only at phase 0.
- R3: An active width of 0 holds `pwm_out` low for the whole period. A width equal to or above `PERIOD` (for example 200 when `PERIOD` is 8) holds it high for the whole period.
- R4: While `rst_n` is low, `pwm_out` is high, and all three event and flag outputs are low. After reset the target width is `PERIOD`, which means full speed.
- R5: When no settling window is open, a cycle with `sw_wr` high loads `sw_width` as the target. In the next cycle, `evt_pwm_changed` is high for one cycle and `use_builtin_tach` is low.
- R6: The level of `temp_code` is the number of thresholds `TEMP_BASE + i*TEMP_STEP` (i = 0 .. `NUM_LEVELS`-1) that it equals or exceeds. The level width for level L is `PERIOD*L/NUM_LEVELS` (integer division). Suppose no window is open, there is no write and no held write, `temp_valid` is high, and the level exceeds the last accepted level. Then the block accepts that level and loads its width as the target. In the next cycle it raises `evt_temp_rise` for one cycle.
- R7: If `evt_temp_rise` is high in cycle c, then `evt_pwm_changed` stays low in cycles c .. c+`SETTLE_CYCLES`-1. In cycle c+`SETTLE_CYCLES` it is high, together with `use_builtin_tach`.
- R8: The following temperature samples cause no event and no width change: samples taken during the settling window, and samples whose level is not above the last accepted level.
- R9: Software writes made during the window are held, and the last one wins. That width is loaded when the window ends. It gives an `evt_pwm_changed` pulse with `use_builtin_tach` low in cycle c+`SETTLE_CYCLES`+1.
- R10: When a software write and a qualifying temperature sample arrive in the same idle cycle, the write is applied. The sample is dropped, and no `evt_temp_rise` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr | input | 1 | Software width write strobe |
| sw_width | input | WID_W | Width value for a software write |
| temp_valid | input | 1 | Temperature sample strobe |
| temp_code | input | TEMP_W | Temperature sample |
| pwm_out | output | 1 | Fan PWM pin |
| period_o | output | WID_W | Read-only PWM period |
| evt_temp_rise | output | 1 | One-cycle pulse: the block has chosen a higher duty |
| evt_pwm_changed | output | 1 | One-cycle pulse: a duty change is complete |
| use_builtin_tach | output | 1 | High: the tach monitor uses built-in expected-period values |

## Verification
The bench builds the block with the following parameters:

- `PERIOD` = 8 with an 8-bit width. Every width from 0 to full can be measured over whole periods in a few cycles. A write of 200 reaches the clamp-high case of R3.
- `SETTLE_CYCLES` = 40 instead of seconds. The window is long enough to inject a higher temperature and two software writes inside it, yet short enough to check its exact length and the held write at its end.
- Four thresholds at 100, 150, 200 and 250. These give level widths 2, 4, 6 and 8, so same-level, lower-level and coincident-write samples can all be aimed at distinct bands.

// File: rtl/fds_pkg.sv
package fds_pkg;

   typedef enum logic {
      SEQ_IDLE   = 1'b0,
      SEQ_SETTLE = 1'b1
   } seq_state_e;

   // width assigned to a temperature level: a proportional share of the period
   function automatic int unsigned scaled_width(int unsigned lvl,
                                                int unsigned period,
                                                int unsigned levels);
      return (period * lvl) / levels;
   endfunction

endpackage

// File: rtl/fds_pwm_gen.sv
module fds_pwm_gen #(
   parameter int unsigned WID_W  = 16,
   parameter int unsigned PERIOD = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WID_W-1:0] tgt_width,
   output logic             pwm_out
);
   localparam logic [WID_W-1:0] LAST = WID_W'(PERIOD - 1);
   localparam logic [WID_W-1:0] FULL = WID_W'(PERIOD);

   logic [WID_W-1:0] phase_q;
   logic [WID_W-1:0] act_q;

   // the active width is swapped only on the wrap, so a period is never cut short
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         act_q   <= FULL;
      end else if (phase_q == LAST) begin
         phase_q <= '0;
         act_q   <= tgt_width;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end

   // full speed while in reset
   assign pwm_out = ~rst_n | (phase_q < act_q);

endmodule

// File: rtl/fds_temp_map.sv
module fds_temp_map #(
   parameter int unsigned TEMP_W     = 12,
   parameter int unsigned WID_W      = 16,
   parameter int unsigned LVL_W      = 3,
   parameter int unsigned NUM_LEVELS = 4,
   parameter int unsigned TEMP_BASE  = 1600,
   parameter int unsigned TEMP_STEP  = 200,
   parameter int unsigned PERIOD     = 1000
) (
   input  logic [TEMP_W-1:0] temp_code,
   output logic [LVL_W-1:0]  level,
   output logic [WID_W-1:0]  level_width
);
   logic [NUM_LEVELS-1:0] hit;

   for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_thr
      localparam logic [TEMP_W-1:0] THR = TEMP_W'(TEMP_BASE + k * TEMP_STEP);
      assign hit[k] = (temp_code >= THR);
   end

   // thresholds ascend, so the highest hit gives the level
   always_comb begin
      level       = '0;
      level_width = '0;
      for (int k = 0; k < NUM_LEVELS; k++) begin
         if (hit[k]) begin
            level       = LVL_W'(k + 1);
            level_width = WID_W'(fds_pkg::scaled_width(k + 1, PERIOD, NUM_LEVELS));
         end
      end
   end

endmodule

// File: rtl/fds_seq_ctrl.sv
module fds_seq_ctrl #(
   parameter int unsigned WID_W         = 16,
   parameter int unsigned LVL_W         = 3,
   parameter int unsigned PERIOD        = 1000,
   parameter int unsigned SETTLE_CYCLES = 500_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr,
   input  logic [WID_W-1:0] sw_width,
   input  logic             temp_valid,
   input  logic [LVL_W-1:0] lvl_now,
   input  logic [WID_W-1:0] lvl_width,
   output logic [WID_W-1:0] tgt_width,
   output logic             evt_temp_rise,
   output logic             evt_pwm_changed,
   output logic             use_builtin_tach
);
   import fds_pkg::*;

   localparam int unsigned       SET_W    = $clog2(SETTLE_CYCLES + 1);
   localparam logic [SET_W-1:0]  SET_LAST = SET_W'(SETTLE_CYCLES - 1);
   localparam logic [WID_W-1:0]  FULL     = WID_W'(PERIOD);

   seq_state_e       state_q;
   logic [SET_W-1:0] wait_q;
   logic [LVL_W-1:0] lvl_acc_q;
   logic             held_vld_q;
   logic [WID_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q          <= SEQ_IDLE;
         wait_q           <= '0;
         lvl_acc_q        <= '0;
         held_vld_q       <= 1'b0;
         held_q           <= '0;
         tgt_width        <= FULL;
         evt_temp_rise    <= 1'b0;
         evt_pwm_changed  <= 1'b0;
         use_builtin_tach <= 1'b0;
      end else begin
         evt_temp_rise   <= 1'b0;
         evt_pwm_changed <= 1'b0;
         if (state_q == SEQ_SETTLE) begin
            // writes are parked; temperature is not looked at
            if (sw_wr) begin
               held_vld_q <= 1'b1;
               held_q     <= sw_width;
            end
            if (wait_q == SET_LAST) begin
               state_q          <= SEQ_IDLE;
               wait_q           <= '0;
               evt_pwm_changed  <= 1'b1;
               use_builtin_tach <= 1'b1;
            end else begin
               wait_q <= wait_q + 1'b1;
            end
         end else if (sw_wr || held_vld_q) begin
            // a fresh write overrides a parked one
            tgt_width        <= sw_wr ? sw_width : held_q;
            held_vld_q       <= 1'b0;
            evt_pwm_changed  <= 1'b1;
            use_builtin_tach <= 1'b0;
         end else if (temp_valid && (lvl_now > lvl_acc_q)) begin
            lvl_acc_q     <= lvl_now;
            tgt_width     <= lvl_width;
            evt_temp_rise <= 1'b1;
            state_q       <= SEQ_SETTLE;
            wait_q        <= '0;
         end
      end
   end

endmodule

// File: rtl/fan_duty_sequencer.sv
module fan_duty_sequencer #(
   parameter int unsigned WID_W         = 16,
   parameter int unsigned PERIOD        = 1000,
   parameter int unsigned TEMP_W        = 12,
   parameter int unsigned NUM_LEVELS    = 4,
   parameter int unsigned TEMP_BASE     = 1600,
   parameter int unsigned TEMP_STEP     = 200,
   parameter int unsigned SETTLE_CYCLES = 500_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic [WID_W-1:0]  sw_width,
   input  logic              temp_valid,
   input  logic [TEMP_W-1:0] temp_code,
   output logic              pwm_out,
   output logic [WID_W-1:0]  period_o,
   output logic              evt_temp_rise,
   output logic              evt_pwm_changed,
   output logic              use_builtin_tach
);
   localparam int unsigned LVL_W = $clog2(NUM_LEVELS + 1);

   if (PERIOD < 2 || PERIOD >= (2 ** WID_W)) begin : g_bad_period
      $error("PERIOD must be at least 2 and fit in WID_W bits");
   end
   if (NUM_LEVELS < 1) begin : g_bad_levels
      $error("NUM_LEVELS must be at least 1");
   end
   if (TEMP_BASE + (NUM_LEVELS - 1) * TEMP_STEP >= (2 ** TEMP_W)) begin : g_bad_thr
      $error("highest threshold must fit in TEMP_W bits");
   end
   if (SETTLE_CYCLES < 2) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 2");
   end

   logic [LVL_W-1:0] lvl_now;
   logic [WID_W-1:0] lvl_width;
   logic [WID_W-1:0] tgt_width;

   assign period_o = WID_W'(PERIOD);

   fds_temp_map #(
      .TEMP_W(TEMP_W), .WID_W(WID_W), .LVL_W(LVL_W), .NUM_LEVELS(NUM_LEVELS),
      .TEMP_BASE(TEMP_BASE), .TEMP_STEP(TEMP_STEP), .PERIOD(PERIOD)
   ) u_map (
      .temp_code   (temp_code),
      .level       (lvl_now),
      .level_width (lvl_width)
   );

   fds_seq_ctrl #(
      .WID_W(WID_W), .LVL_W(LVL_W), .PERIOD(PERIOD), .SETTLE_CYCLES(SETTLE_CYCLES)
   ) u_seq (
      .clk              (clk),
      .rst_n            (rst_n),
      .sw_wr            (sw_wr),
      .sw_width         (sw_width),
      .temp_valid       (temp_valid),
      .lvl_now          (lvl_now),
      .lvl_width        (lvl_width),
      .tgt_width        (tgt_width),
      .evt_temp_rise    (evt_temp_rise),
      .evt_pwm_changed  (evt_pwm_changed),
      .use_builtin_tach (use_builtin_tach)
   );

   fds_pwm_gen #(
      .WID_W(WID_W), .PERIOD(PERIOD)
   ) u_pwm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tgt_width (tgt_width),
      .pwm_out   (pwm_out)
   );

endmodule

// File: rtl/fds_checker.sv
module fds_checker #(
   parameter int unsigned PERIOD        = 1000,
   parameter int unsigned SETTLE_CYCLES = 500_000_000
) (
   input logic clk,
   input logic rst_n,
   input logic sw_wr,
   input logic pwm_out,
   input logic evt_temp_rise,
   input logic evt_pwm_changed,
   input logic use_builtin_tach
);
   localparam logic [31:0] S_LEN  = 32'(SETTLE_CYCLES);
   localparam logic [31:0] P_LAST = 32'(PERIOD - 1);

   logic [31:0] since_rise;
   logic [31:0] phase;
   logic        chk_pend;
   logic        in_window;

   assign in_window = evt_temp_rise || ((since_rise != 32'd0) && (since_rise < S_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rise <= '0;
         phase      <= '0;
         chk_pend   <= 1'b0;
      end else begin
         phase <= (phase == P_LAST) ? 32'd0 : phase + 32'd1;
         if (evt_temp_rise)          since_rise <= 32'd1;
         else if (since_rise == S_LEN) since_rise <= 32'd0;
         else if (since_rise != 32'd0) since_rise <= since_rise + 32'd1;
         if (since_rise == S_LEN)     chk_pend <= 1'b0;
         else if (sw_wr && in_window) chk_pend <= 1'b1;
      end
   end

   a_r2_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> (phase == 32'd0));

   a_r5_sw_change: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && !in_window) |=> (evt_pwm_changed && !use_builtin_tach));

   a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      evt_temp_rise |=> !evt_temp_rise);

   a_r7_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
      in_window |-> !evt_pwm_changed);

   a_r7_change_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rise == S_LEN) |-> (evt_pwm_changed && use_builtin_tach));

   a_r8_no_rise_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rise != 32'd0) && (since_rise <= S_LEN)) |-> !evt_temp_rise);

   a_r9_held_applied: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rise == S_LEN) && chk_pend) |=> (evt_pwm_changed && !use_builtin_tach));

endmodule

bind fan_duty_sequencer fds_checker #(
   .PERIOD(PERIOD), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_fds_checker (
   .clk              (clk),
   .rst_n            (rst_n),
   .sw_wr            (sw_wr),
   .pwm_out          (pwm_out),
   .evt_temp_rise    (evt_temp_rise),
   .evt_pwm_changed  (evt_pwm_changed),
   .use_builtin_tach (use_builtin_tach)
);

// File: tb/test_fan_duty_sequencer.sv
module test_fan_duty_sequencer;
   localparam int WW = 8, P = 8, TW = 10, NL = 4, TB = 100, TS = 50, S = 40;

   logic          clk = 1'b0, rst_n = 1'b0, sw_wr = 1'b0, temp_valid = 1'b0;
   logic [WW-1:0] sw_width = '0;
   logic [TW-1:0] temp_code = '0;
   logic          pwm_out, evt_temp_rise, evt_pwm_changed, use_builtin_tach;
   logic [WW-1:0] period_o;

   fan_duty_sequencer #(
      .WID_W(WW), .PERIOD(P), .TEMP_W(TW), .NUM_LEVELS(NL),
      .TEMP_BASE(TB), .TEMP_STEP(TS), .SETTLE_CYCLES(S)
   ) i_fan_duty_sequencer (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_width(sw_width),
      .temp_valid(temp_valid), .temp_code(temp_code), .pwm_out(pwm_out),
      .period_o(period_o), .evt_temp_rise(evt_temp_rise),
      .evt_pwm_changed(evt_pwm_changed), .use_builtin_tach(use_builtin_tach)
   );

   always #5 clk = ~clk;

   int n_vec = 0, n_bad = 0, cyc = 0;
   bit done = 0;
   int n_rise = 0, n_chg = 0, rise_at = 0, chg_at = 0, chg_bi = 0;

   task automatic chk(string tag, int act, int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // ---------------- behavioural reference ----------------
   int m_cnt, m_act, m_tgt, m_lvl, m_left, m_held;
   bit m_settling, m_pend, m_evr, m_evc, m_bi;

   function automatic int level_of(int t);
      int n = 0;
      for (int i = 0; i < NL; i++) if (t >= TB + i * TS) n++;
      return n;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_act = P; m_tgt = P; m_lvl = 0; m_left = 0; m_held = 0;
         m_settling = 0; m_pend = 0; m_evr = 0; m_evc = 0; m_bi = 0;
      end else begin
         if (m_cnt == P - 1) begin m_cnt = 0; m_act = m_tgt; end
         else m_cnt++;
         m_evr = 0; m_evc = 0;
         if (m_settling) begin
            if (sw_wr) begin m_pend = 1; m_held = int'(sw_width); end
            if (m_left == 1) begin m_settling = 0; m_evc = 1; m_bi = 1; end
            else m_left--;
         end else if (sw_wr) begin
            m_tgt = int'(sw_width); m_pend = 0; m_evc = 1; m_bi = 0;
         end else if (m_pend) begin
            m_tgt = m_held; m_pend = 0; m_evc = 1; m_bi = 0;
         end else if (temp_valid && level_of(int'(temp_code)) > m_lvl) begin
            m_lvl = level_of(int'(temp_code));
            m_tgt = (P * m_lvl) / NL;
            m_evr = 1; m_settling = 1; m_left = S;
         end
      end
   end

   // per-cycle comparison and event log
   always @(negedge clk) begin
      chk("R2 pwm_out vs model", int'(pwm_out), (!rst_n || m_cnt < m_act) ? 1 : 0);
      chk("R6 evt_temp_rise vs model", int'(evt_temp_rise), int'(m_evr));
      chk("R5 evt_pwm_changed vs model", int'(evt_pwm_changed), int'(m_evc));
      chk("R7 use_builtin_tach vs model", int'(use_builtin_tach), int'(m_bi));
      chk("R1 period_o", int'(period_o), P);
      if (evt_temp_rise)   begin n_rise++; rise_at = cyc; end
      if (evt_pwm_changed) begin n_chg++; chg_at = cyc; chg_bi = int'(use_builtin_tach); end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic apply(bit wr, int w, bit tv, int t);
      sw_wr = wr; sw_width = WW'(w); temp_valid = tv; temp_code = TW'(t);
      @(posedge clk); #1;
      sw_wr = 1'b0; temp_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic after_edge();
      @(negedge clk); #1;
   endtask

   task automatic measure(output int hi);
      hi = 0;
      repeat (P) begin @(negedge clk); #1; hi += int'(pwm_out); end
   endtask

   int hi, r0, c0, first_chg;

   initial begin
      // R4: reset state
      repeat (3) begin @(negedge clk); #1; chk("R4 pwm high in reset", int'(pwm_out), 1); end
      @(posedge clk); #1; rst_n = 1'b1;
      after_edge();
      chk("R4 evt_temp_rise after reset", int'(evt_temp_rise), 0);
      chk("R4 evt_pwm_changed after reset", int'(evt_pwm_changed), 0);
      chk("R4 use_builtin_tach after reset", int'(use_builtin_tach), 0);
      measure(hi); chk("R4 full width after reset", hi, P);

      // R5 / R1: software write while idle
      c0 = n_chg;
      apply(1, 3, 0, 0); after_edge();
      chk("R5 change pulse after write", n_chg, c0 + 1);
      chk("R5 flag low after write", int'(use_builtin_tach), 0);
      idle(2 * P); measure(hi); chk("R1 high cycles for width 3", hi, 3);

      // R3: extremes
      apply(1, 0, 0, 0);   idle(2 * P); measure(hi); chk("R3 width 0 low", hi, 0);
      apply(1, 200, 0, 0); idle(2 * P); measure(hi); chk("R3 width over period high", hi, P);
      apply(1, 3, 0, 0);   idle(2 * P);

      // R6 / R7 / R8 / R9: hardware request with activity inside the window
      r0 = n_rise; c0 = n_chg;
      apply(0, 0, 1, 160); after_edge();
      chk("R6 rise pulse for level 2", n_rise, r0 + 1);
      idle(P); measure(hi); chk("R6 level 2 width", hi, 4);
      apply(0, 0, 1, 260);
      apply(1, 5, 0, 0);
      apply(1, 7, 0, 0);
      chk("R8 no rise inside window", n_rise, r0 + 1);
      chk("R7 no change inside window", n_chg, c0);
      for (int i = 0; i < S + 10 && n_chg == c0; i++) after_edge();
      first_chg = chg_at;
      chk("R7 settle length", chg_at - rise_at, S);
      chk("R7 flag set at window end", chg_bi, 1);
      after_edge();
      chk("R9 held write change pulse", n_chg, c0 + 2);
      chk("R9 held write one cycle later", chg_at - first_chg, 1);
      chk("R9 flag cleared by held write", chg_bi, 0);
      idle(2 * P); measure(hi); chk("R9 last held write wins", hi, 7);

      // R8: same or lower level is ignored
      r0 = n_rise; c0 = n_chg;
      apply(0, 0, 1, 160); apply(0, 0, 1, 110); idle(3);
      chk("R8 no rise for same or lower level", n_rise, r0);
      chk("R8 no change for same or lower level", n_chg, c0);
      measure(hi); chk("R8 width kept", hi, 7);

      // R10: write and temperature request together
      r0 = n_rise; c0 = n_chg;
      apply(1, 1, 1, 210); after_edge();
      chk("R10 write applied", n_chg, c0 + 1);
      idle(3);
      chk("R10 temperature dropped", n_rise, r0);
      idle(2 * P); measure(hi); chk("R10 written width", hi, 1);
      apply(0, 0, 1, 210); after_edge();
      chk("R6 rise for level 3", n_rise, r0 + 1);
      idle(S + 4); measure(hi); chk("R6 level 3 width", hi, 6);

      done = 1;
      summary();
      $finish;
   end

endmodule